// File: doc/BRIEF.md
# Host Port Request and Flag Control

This block is the control and status slice of a parallel port that joins an external host processor to a DSP core. It keeps a host-writable control word holding three request enables, a DMA mode select, two flags the host raises toward the DSP, and two read-only copies of flags that only the DSP side can change. The two host flags also appear in a DSP-side status word, so each side sees the other's signalling.

From four buffer conditions (DSP receive full, host transmit full, DSP transmit empty, host receive empty), the block forms a host request. In interrupt mode the request is an enable-selected mix of these conditions. In DMA mode it is a single-direction transfer request, and the block also reports which way the transfer runs. The request is given both as a combinational flag and as a registered active-low pin for the host.

Top module: `hostreq_ctl`

## Requirements
- R1: After the asynchronous reset, host_ctrl_q and dsp_status_q are all zero, req_flag is 0, req_n is 1 and dma_dir is 2'b00.
- R2: A host write stores data bits 8 and 9 as host flags 0 and 1. One clock later they show in host_ctrl_q bits 8 and 9 and in dsp_status_q bits 3 and 4. All other dsp_status_q bits read 0.
- R3: A DSP flag write stores dsp_flag_wr_data[0] and [1] in host_ctrl_q bits 10 and 11, one clock later. A host write leaves those two bits unchanged.
- R4: Control bit 0 is the transmit request enable, bit 1 the receive request enable, bit 2 the joint enable and bit 12 the DMA mode (1 = DMA). These read back as written. Unused control bits read 0.
- R5: In interrupt mode with the joint enable clear, req_flag = (rx_en & (rx_full | htx_full)) | (tx_en & (tx_empty | hrx_empty)). Code 0,0,0 never requests.
- R6: In interrupt mode with the joint enable set, tx_en is ignored. With rx_en = 0, req_flag = tx_empty & hrx_empty. With rx_en = 1, req_flag is the OR of all four conditions.
- R7: In DMA mode, enables tx=0, rx=1, joint=0 make req_flag = rx_full with dma_dir = 2'b01 (DSP to memory). Enables tx=1, rx=0, joint=0 make req_flag = tx_empty with dma_dir = 2'b10 (memory to DSP). dma_dir is 2'b00 in interrupt mode.
- R8: In DMA mode, every other enable code keeps req_flag at 0 and dma_dir at 2'b00.
- R9: req_n equals the inverse of req_flag as it was one clock earlier.
- R10: The synchronous sw_rst clears all control bits and both DSP flags on the next clock, and drives req_n to 1 on that clock. It takes priority over both write ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous software reset |
| host_wr_en | input | 1 | Host write strobe for the control word |
| host_wr_data | input | CTRL_W | Host write data |
| dsp_flag_wr_en | input | 1 | DSP write strobe for its two flags |
| dsp_flag_wr_data | input | 2 | DSP flag values (bit 0 to flag 2, bit 1 to flag 3) |
| rx_full | input | 1 | DSP receive register full |
| htx_full | input | 1 | Host transmit register full |
| tx_empty | input | 1 | DSP transmit register empty |
| hrx_empty | input | 1 | Host receive register empty |
| host_ctrl_q | output | CTRL_W | Control word as the host reads it |
| dsp_status_q | output | STAT_W | DSP-side status word carrying host flags |
| req_flag | output | 1 | Combinational host request |
| req_n | output | 1 | Registered active-low host request pin |
| dma_dir | output | 2 | Transfer direction: 00 none, 01 DSP to memory, 10 memory to DSP |

## Verification
A corrupted enable or mode bit shows up in the same cycle as a wrong req_flag for some buffer pattern, and on req_n one clock later. The bench therefore sweeps every mode, every enable code and all sixteen buffer patterns. A wrong flag register shows up one clock after the write, on the opposite side's word, so both mirroring directions are read back right after each write. A wrong reset or priority shows on the first clock after sw_rst, while a write is held active at the same time.

// File: rtl/hreq_pkg.sv
package hreq_pkg;
  localparam int BIT_TXEN = 0;
  localparam int BIT_RXEN = 1;
  localparam int BIT_JNEN = 2;
  localparam int BIT_HF0  = 8;
  localparam int BIT_HF1  = 9;
  localparam int BIT_HF2  = 10;
  localparam int BIT_HF3  = 11;
  localparam int BIT_DMAM = 12;
  localparam int STAT_HF0 = 3;
  localparam int STAT_HF1 = 4;
  localparam int NUM_EN   = 3;

  typedef enum logic [1:0] {
    DIR_NONE    = 2'b00,
    DIR_DSP2MEM = 2'b01,
    DIR_MEM2DSP = 2'b10
  } dma_dir_e;

  typedef struct packed {
    logic       dma_mode;
    logic [1:0] hf_dsp;
    logic [1:0] hf_host;
    logic [NUM_EN-1:0] en;
  } ctrl_s;
endpackage

// File: rtl/hreq_ctrl_reg.sv
module hreq_ctrl_reg
  import hreq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_rst,
  input  logic       host_wr_en,
  input  logic [NUM_EN-1:0] host_en_d,
  input  logic [1:0] host_hf_d,
  input  logic       host_dma_d,
  input  logic       dsp_wr_en,
  input  logic [1:0] dsp_hf_d,
  output ctrl_s      ctrl_q
);
  ctrl_s ctrl_d;
  logic  ctrl_ce;

  always_comb begin
    ctrl_d  = ctrl_q;
    ctrl_ce = sw_rst | host_wr_en | dsp_wr_en;
    if (sw_rst) begin
      ctrl_d = '0;
    end else begin
      if (host_wr_en) begin
        ctrl_d.en       = host_en_d;
        ctrl_d.hf_host  = host_hf_d;
        ctrl_d.dma_mode = host_dma_d;
      end
      if (dsp_wr_en) begin
        ctrl_d.hf_dsp = dsp_hf_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_ce) begin
      ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/hreq_req_logic.sv
module hreq_req_logic
  import hreq_pkg::*;
(
  input  logic       dma_mode,
  input  logic [NUM_EN-1:0] en,
  input  logic       rx_full,
  input  logic       htx_full,
  input  logic       tx_empty,
  input  logic       hrx_empty,
  output logic       req,
  output dma_dir_e   dir
);
  logic tx_en, rx_en, jn_en;
  logic rx_side, tx_side;

  assign tx_en   = en[BIT_TXEN];
  assign rx_en   = en[BIT_RXEN];
  assign jn_en   = en[BIT_JNEN];
  assign rx_side = rx_full | htx_full;
  assign tx_side = tx_empty | hrx_empty;

  always_comb begin
    req = 1'b0;
    dir = DIR_NONE;
    if (dma_mode) begin
      unique case ({tx_en, rx_en, jn_en})
        3'b010: begin
          req = rx_full;
          dir = DIR_DSP2MEM;
        end
        3'b100: begin
          req = tx_empty;
          dir = DIR_MEM2DSP;
        end
        default: begin
          req = 1'b0;
          dir = DIR_NONE;
        end
      endcase
    end else if (!jn_en) begin
      req = (rx_en & rx_side) | (tx_en & tx_side);
    end else if (!rx_en) begin
      req = tx_empty & hrx_empty;
    end else begin
      req = rx_side | tx_side;
    end
  end
endmodule

// File: rtl/hreq_pin.sv
module hreq_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst,
  input  logic req,
  output logic req_n
);
  logic pin_d;

  always_comb begin
    pin_d = sw_rst ? 1'b1 : ~req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_n <= 1'b1;
    end else begin
      req_n <= pin_d;
    end
  end
endmodule

// File: rtl/hostreq_ctl.sv
module hostreq_ctl
  import hreq_pkg::*;
#(
  parameter int CTRL_W = 16,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              host_wr_en,
  input  logic [CTRL_W-1:0] host_wr_data,
  input  logic              dsp_flag_wr_en,
  input  logic [1:0]        dsp_flag_wr_data,
  input  logic              rx_full,
  input  logic              htx_full,
  input  logic              tx_empty,
  input  logic              hrx_empty,
  output logic [CTRL_W-1:0] host_ctrl_q,
  output logic [STAT_W-1:0] dsp_status_q,
  output logic              req_flag,
  output logic              req_n,
  output logic [1:0]        dma_dir
);
  localparam int EN_LSB = BIT_TXEN;
  localparam int EN_MSB = BIT_TXEN + NUM_EN - 1;

  ctrl_s    ctrl_q;
  dma_dir_e dir_w;

  hreq_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_rst     (sw_rst),
    .host_wr_en (host_wr_en),
    .host_en_d  (host_wr_data[EN_MSB:EN_LSB]),
    .host_hf_d  (host_wr_data[BIT_HF1:BIT_HF0]),
    .host_dma_d (host_wr_data[BIT_DMAM]),
    .dsp_wr_en  (dsp_flag_wr_en),
    .dsp_hf_d   (dsp_flag_wr_data),
    .ctrl_q     (ctrl_q)
  );

  hreq_req_logic u_req (
    .dma_mode  (ctrl_q.dma_mode),
    .en        (ctrl_q.en),
    .rx_full   (rx_full),
    .htx_full  (htx_full),
    .tx_empty  (tx_empty),
    .hrx_empty (hrx_empty),
    .req       (req_flag),
    .dir       (dir_w)
  );

  hreq_pin u_pin (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_rst (sw_rst),
    .req    (req_flag),
    .req_n  (req_n)
  );

  assign dma_dir = dir_w;

  // Host-side readback: place each field at its bit, zero elsewhere
  for (genvar i = 0; i < CTRL_W; i++) begin : g_ctrl_rd
    if (i >= EN_LSB && i <= EN_MSB) begin : g_en
      assign host_ctrl_q[i] = ctrl_q.en[i-EN_LSB];
    end else if (i == BIT_HF0 || i == BIT_HF1) begin : g_hh
      assign host_ctrl_q[i] = ctrl_q.hf_host[i-BIT_HF0];
    end else if (i == BIT_HF2 || i == BIT_HF3) begin : g_hd
      assign host_ctrl_q[i] = ctrl_q.hf_dsp[i-BIT_HF2];
    end else if (i == BIT_DMAM) begin : g_dm
      assign host_ctrl_q[i] = ctrl_q.dma_mode;
    end else begin : g_zero
      assign host_ctrl_q[i] = 1'b0;
    end
  end

  // DSP-side status: host flags at their status positions
  for (genvar j = 0; j < STAT_W; j++) begin : g_stat
    if (j == STAT_HF0 || j == STAT_HF1) begin : g_hf
      assign dsp_status_q[j] = ctrl_q.hf_host[j-STAT_HF0];
    end else begin : g_zero
      assign dsp_status_q[j] = 1'b0;
    end
  end
endmodule

// File: rtl/hreq_chk.sv
module hreq_chk
  import hreq_pkg::*;
#(
  parameter int CTRL_W = 16,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_rst,
  input logic              host_wr_en,
  input logic [CTRL_W-1:0] host_wr_data,
  input logic              dsp_flag_wr_en,
  input logic [1:0]        dsp_flag_wr_data,
  input logic [CTRL_W-1:0] host_ctrl_q,
  input logic [STAT_W-1:0] dsp_status_q,
  input logic              req_flag,
  input logic              req_n
);
  // R2
  hf_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && !sw_rst) |=>
      (dsp_status_q[STAT_HF0] == $past(host_wr_data[BIT_HF0]) &&
       dsp_status_q[STAT_HF1] == $past(host_wr_data[BIT_HF1])));

  // R3
  dsp_flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && !dsp_flag_wr_en && !sw_rst) |=>
      $stable(host_ctrl_q[BIT_HF3:BIT_HF2]));

  // R3
  dsp_flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_flag_wr_en && !sw_rst) |=>
      (host_ctrl_q[BIT_HF3:BIT_HF2] == $past(dsp_flag_wr_data)));

  // R5
  poll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ctrl_q[BIT_DMAM] == 1'b0 && host_ctrl_q[BIT_JNEN:BIT_TXEN] == 3'b000)
      |-> !req_flag);

  // R8
  dma_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ctrl_q[BIT_DMAM] && host_ctrl_q[BIT_JNEN:BIT_TXEN] != 3'b010 &&
     host_ctrl_q[BIT_JNEN:BIT_TXEN] != 3'b001) |-> !req_flag);

  // R9
  pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rst |=> (req_n == !$past(req_flag)));

  // R10
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (host_ctrl_q == '0 && req_n));
endmodule

bind hostreq_ctl hreq_chk #(.CTRL_W(CTRL_W), .STAT_W(STAT_W)) i_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .sw_rst           (sw_rst),
  .host_wr_en       (host_wr_en),
  .host_wr_data     (host_wr_data),
  .dsp_flag_wr_en   (dsp_flag_wr_en),
  .dsp_flag_wr_data (dsp_flag_wr_data),
  .host_ctrl_q      (host_ctrl_q),
  .dsp_status_q     (dsp_status_q),
  .req_flag         (req_flag),
  .req_n            (req_n)
);

// File: tb/test_hostreq_ctl.sv
`timescale 1ns/1ps
module test_hostreq_ctl;
  localparam int CW = 16;
  localparam int SW = 8;

  logic          clk;
  logic          rst_n;
  logic          sw_rst;
  logic          host_wr_en;
  logic [CW-1:0] host_wr_data;
  logic          dsp_flag_wr_en;
  logic [1:0]    dsp_flag_wr_data;
  logic          rx_full, htx_full, tx_empty, hrx_empty;
  logic [CW-1:0] host_ctrl_q;
  logic [SW-1:0] dsp_status_q;
  logic          req_flag;
  logic          req_n;
  logic [1:0]    dma_dir;

  int n_checks;
  int n_errors;

  hostreq_ctl #(.CTRL_W(CW), .STAT_W(SW)) i_hostreq_ctl (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .dsp_flag_wr_en(dsp_flag_wr_en), .dsp_flag_wr_data(dsp_flag_wr_data),
    .rx_full(rx_full), .htx_full(htx_full), .tx_empty(tx_empty), .hrx_empty(hrx_empty),
    .host_ctrl_q(host_ctrl_q), .dsp_status_q(dsp_status_q),
    .req_flag(req_flag), .req_n(req_n), .dma_dir(dma_dir)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic ref_req(input logic dm, input logic tx, input logic rx, input logic jn,
                                   input logic [3:0] st);
    logic rf, hf, te, he;
    {he, te, hf, rf} = st;
    if (dm) begin
      if ({tx, rx, jn} == 3'b010) return rf;
      if ({tx, rx, jn} == 3'b100) return te;
      return 1'b0;
    end
    if (!jn) return (rx & (rf | hf)) | (tx & (te | he));
    if (!rx) return te & he;
    return rf | hf | te | he;
  endfunction

  function automatic logic [1:0] ref_dir(input logic dm, input logic [2:0] code);
    if (dm && code == 3'b010) return 2'b01;
    if (dm && code == 3'b100) return 2'b10;
    return 2'b00;
  endfunction

  task automatic host_write(input logic [CW-1:0] d);
    @(negedge clk);
    host_wr_en   = 1'b1;
    host_wr_data = d;
    @(negedge clk);
    host_wr_en   = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    sw_rst = 1'b0; host_wr_en = 1'b0; host_wr_data = '0;
    dsp_flag_wr_en = 1'b0; dsp_flag_wr_data = '0;
    {rx_full, htx_full, tx_empty, hrx_empty} = 4'b1111;
    repeat (3) @(negedge clk);
    check("R1 ctrl", 32'(host_ctrl_q), 32'h0);
    check("R1 status", 32'(dsp_status_q), 32'h0);
    check("R1 req_n", 32'(req_n), 32'h1);
    check("R1 req_flag", 32'(req_flag), 32'h0);
    check("R1 dir", 32'(dma_dir), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req_n after release", 32'(req_n), 32'h1);
  endtask

  task automatic t_host_flags;
    {rx_full, htx_full, tx_empty, hrx_empty} = 4'b0000;
    host_write(16'h0100);
    check("R2 status hf0", 32'(dsp_status_q), 32'h08);
    check("R2 ctrl hf0", 32'(host_ctrl_q), 32'h0100);
    host_write(16'h0200);
    check("R2 status hf1", 32'(dsp_status_q), 32'h10);
    // R4: full write, read-only bits and unused bits stay 0
    host_write(16'hFFFF);
    check("R4 readback", 32'(host_ctrl_q), 32'h1307);
    check("R2 status both", 32'(dsp_status_q), 32'h18);
    host_write(16'h0000);
    check("R2 status clear", 32'(dsp_status_q), 32'h00);
  endtask

  task automatic t_dsp_flags;
    @(negedge clk);
    dsp_flag_wr_en = 1'b1; dsp_flag_wr_data = 2'b01;
    @(negedge clk);
    dsp_flag_wr_en = 1'b0;
    check("R3 dsp hf2", 32'(host_ctrl_q[11:10]), 32'h1);
    @(negedge clk);
    dsp_flag_wr_en = 1'b1; dsp_flag_wr_data = 2'b10;
    @(negedge clk);
    dsp_flag_wr_en = 1'b0;
    check("R3 dsp hf3", 32'(host_ctrl_q[11:10]), 32'h2);
    check("R3 status untouched", 32'(dsp_status_q), 32'h00);
    host_write(16'h0C00);
    check("R3 host write ignored", 32'(host_ctrl_q[11:10]), 32'h2);
    host_write(16'h0000);
    check("R3 host clear ignored", 32'(host_ctrl_q[11:10]), 32'h2);
  endtask

  task automatic t_sweep;
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 8; c++) begin
        logic [CW-1:0] d;
        d = '0;
        d[12] = m[0];
        d[2:0] = c[2:0];
        host_write(d);
        for (int s = 0; s < 16; s++) begin
          logic er;
          string tag;
          {hrx_empty, tx_empty, htx_full, rx_full} = s[3:0];
          er = ref_req(m[0], c[0], c[1], c[2], s[3:0]);
          if (m == 1) tag = (c == 2 || c == 1) ? "R7" : "R8";
          else tag = c[2] ? "R6" : "R5";
          #1;
          check($sformatf("%s req m=%0d c=%0d s=%0d", tag, m, c, s), 32'(req_flag), 32'(er));
          check($sformatf("R7 dir m=%0d c=%0d", m, c), 32'(dma_dir),
                32'(ref_dir(m[0], {c[0], c[1], c[2]})));
          @(negedge clk);
          check($sformatf("R9 pin m=%0d c=%0d s=%0d", m, c, s), 32'(req_n), 32'(!er));
        end
      end
    end
  endtask

  task automatic t_swrst;
    host_write(16'h1302);
    {rx_full, htx_full, tx_empty, hrx_empty} = 4'b1000;
    @(negedge clk);
    check("R7 setup req_n", 32'(req_n), 32'h0);
    sw_rst = 1'b1;
    host_wr_en = 1'b1; host_wr_data = 16'h1302;
    dsp_flag_wr_en = 1'b1; dsp_flag_wr_data = 2'b11;
    @(negedge clk);
    check("R10 ctrl cleared", 32'(host_ctrl_q), 32'h0);
    check("R10 req_n high", 32'(req_n), 32'h1);
    check("R10 status cleared", 32'(dsp_status_q), 32'h0);
    sw_rst = 1'b0; host_wr_en = 1'b0; dsp_flag_wr_en = 1'b0;
    @(negedge clk);
    check("R10 stays clear", 32'(host_ctrl_q), 32'h0);
  endtask

  initial begin
    n_checks = 0;
    n_errors = 0;
    t_reset();
    t_host_flags();
    t_dsp_flags();
    t_sweep();
    t_swrst();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #2000000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule